// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control core of a 10-bit successive-approximation converter. Software reaches it through a small 16-bit register interface: two control words and a read-only result word. From a divided clock it opens a sample window and then a conversion window. When the conversion period ends it captures the code returned by the converter, raises an interrupt flag and presents the result in one of two justified formats. It can convert one channel once, step down through a range of channels, or repeat either of these. Conversions start on a software start bit or on one of three timer outputs, and the selected signal can be inverted first.

The analog converter sits outside the block. The controller drives `conv_hold` during the sample window and `conv_chan` for the channel being converted, and it reads `conv_code` on the last divided clock of the 13-tick conversion period. Write address 0 is the control word A, address 1 is the control word B and address 2 is the result. Reads are combinational on `rd_addr`, and address 3 reads as zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, control word A, control word B and the result word read 0, and `busy` and `irq` are 0.
- R2: The sample window lasts S divided ticks, where S is 4, 8, 16 or 64 for sample code A[6:5] = 0, 1, 2 or 3. The conversion then lasts 13 ticks. One tick is (B[4:2] + 1) clocks. `busy` stays 1 for exactly (S + 13)·(B[4:2] + 1) clocks, and `conv_hold` is 1 for the first S·(B[4:2] + 1) of them.
- R3: In mode B[1:0] = 0, one trigger converts channel B[15:12] once, and the block then returns to idle.
- R4: In mode B[1:0] = 1, the block converts from channel B[15:12] down to channel 0 and then goes idle.
- R5: Modes B[1:0] = 2 (repeat one channel) and 3 (repeat the descending range) keep converting until the enable bit A[1] is cleared. A conversion already running is completed first. Once the block is idle, later triggers start nothing while A[1] is 0.
- R6: With auto bit A[4] = 0, each conversion in modes 1 to 3 needs its own trigger edge. With A[4] = 1, the next conversion starts as soon as the previous one completes. A trigger edge that arrives while a sample or conversion runs is ignored.
- R7: The trigger source B[6:5] selects the start bit (0) or timer input `tmr_trig[0]`, `[1]` or `[2]` (1, 2, 3). Invert bit B[7] complements the source before rising-edge detection. Sources that are not selected have no effect.
- R8: Start bit A[0] reads back 0 after its write. It may be set in the same write that sets the enable bit A[1], and that write starts a conversion.
- R9: While A[1] is 1, writes leave the sample code A[6:5], the auto bit A[4], the mode B[1:0], the trigger source B[6:5] and the channel B[15:12] unchanged. The divider B[4:2], the invert bit B[7] and the format bit B[8] still take writes.
- R10: Flag A[2] sets when a result is loaded. It clears on `irq_ack` or on a write of 0 to it. `irq` equals A[2] AND interrupt enable A[3].
- R11: With format bit B[8] = 0, the result reads as the 10-bit code in bits 9..0 with the upper bits 0. With B[8] = 1, it reads as the code with its MSB inverted, placed in bits 15..6, with bits 5..0 set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 = A, 1 = B) |
| wdata | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 = A, 1 = B, 2 = result) |
| rdata | output | 16 | Read data, combinational |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| tmr_trig | input | 3 | Timer trigger inputs |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A sample, a conversion or a sequence is active |
| conv_hold | output | 1 | Sample window active |
| conv_chan | output | 4 | Channel being sampled or converted |
| conv_code | input | 10 | Code from the converter, read at the end of the conversion |

## Verification
The assertions assume that `tmr_trig` is already synchronous to `clk`. They also assume that `conv_code` holds steady from the end of the sample window until it is read, and that `irq_ack` comes only while the flag is set and never in the cycle a result loads. The bench drives timer pulses at falling clock edges and keeps each one high for two clocks, starting from the idle level chosen by the invert bit. Its converter model derives the code only from `conv_chan` and a value that is constant within each case. It acknowledges each interrupt once, more than a full conversion before the next result can arrive.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_t;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_SEQ    = 2'd1;
  localparam logic [1:0] MODE_REP1   = 2'd2;
  localparam logic [1:0] MODE_REPSEQ = 2'd3;

  localparam logic [1:0] ADDR_CTL_A = 2'd0;
  localparam logic [1:0] ADDR_CTL_B = 2'd1;
  localparam logic [1:0] ADDR_RES   = 2'd2;

  // control word A field positions
  localparam int A_GO   = 0;
  localparam int A_EN   = 1;
  localparam int A_FLAG = 2;
  localparam int A_IE   = 3;
  localparam int A_AUTO = 4;
  localparam int A_SHT  = 5;

  // control word B field positions
  localparam int B_MODE = 0;
  localparam int B_DIV  = 2;
  localparam int B_TSEL = 5;
  localparam int B_INV  = 7;
  localparam int B_FMT  = 8;

  localparam int CONV_TICKS = 13;
  localparam int TICK_W     = 7;

  function automatic logic [TICK_W-1:0] sample_len(input logic [1:0] code);
    case (code)
      2'd0:    sample_len = 7'd4;
      2'd1:    sample_len = 7'd8;
      2'd2:    sample_len = 7'd16;
      default: sample_len = 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int BUSW = 16,
  parameter int CHW  = 4,
  parameter int DIVW = 3,
  parameter int TSW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [BUSW-1:0] wdata,
  input  logic            res_load,
  input  logic            irq_ack,
  output logic            go,
  output logic            en,
  output logic            flag,
  output logic            ie,
  output logic            auto_go,
  output logic [1:0]      sht,
  output logic [1:0]      mode,
  output logic [DIVW-1:0] div,
  output logic [TSW-1:0]  tsel,
  output logic            inv,
  output logic            fmt,
  output logic [CHW-1:0]  chan
);

  localparam int CH_LSB = BUSW - CHW;

  logic            wr_a, wr_b;
  logic            go_n, en_n, flag_n, ie_n, auto_n, inv_n, fmt_n;
  logic [1:0]      sht_n, mode_n;
  logic [DIVW-1:0] div_n;
  logic [TSW-1:0]  tsel_n;
  logic [CHW-1:0]  chan_n;

  assign wr_a = wr_en && (wr_addr == ADDR_CTL_A);
  assign wr_b = wr_en && (wr_addr == ADDR_CTL_B);

  always_comb begin
    go_n   = wr_a & wdata[A_GO];
    en_n   = en;
    ie_n   = ie;
    flag_n = flag;
    sht_n  = sht;
    auto_n = auto_go;
    mode_n = mode;
    div_n  = div;
    tsel_n = tsel;
    inv_n  = inv;
    fmt_n  = fmt;
    chan_n = chan;

    if (wr_a) begin
      en_n = wdata[A_EN];
      ie_n = wdata[A_IE];
      if (!en) begin
        sht_n  = wdata[A_SHT +: 2];
        auto_n = wdata[A_AUTO];
      end
    end

    if (res_load)     flag_n = 1'b1;
    else if (wr_a)    flag_n = wdata[A_FLAG];
    else if (irq_ack) flag_n = 1'b0;

    if (wr_b) begin
      div_n = wdata[B_DIV +: DIVW];
      inv_n = wdata[B_INV];
      fmt_n = wdata[B_FMT];
      if (!en) begin
        mode_n = wdata[B_MODE +: 2];
        tsel_n = wdata[B_TSEL +: TSW];
        chan_n = wdata[CH_LSB +: CHW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go      <= 1'b0;
      en      <= 1'b0;
      ie      <= 1'b0;
      flag    <= 1'b0;
      sht     <= '0;
      auto_go <= 1'b0;
      mode    <= '0;
      div     <= '0;
      tsel    <= '0;
      inv     <= 1'b0;
      fmt     <= 1'b0;
      chan    <= '0;
    end else begin
      go      <= go_n;
      en      <= en_n;
      ie      <= ie_n;
      flag    <= flag_n;
      sht     <= sht_n;
      auto_go <= auto_n;
      mode    <= mode_n;
      div     <= div_n;
      tsel    <= tsel_n;
      inv     <= inv_n;
      fmt     <= fmt_n;
      chan    <= chan_n;
    end
  end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int NTMR = 3,
  parameter int TSW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [NTMR-1:0] tmr,
  input  logic [TSW-1:0]  tsel,
  input  logic            inv,
  output logic            trig
);

  logic [NTMR:0] srcs;
  logic          sel_raw, sig, sig_q;

  assign srcs = {tmr, go};

  always_comb begin
    sel_raw = 1'b0;
    for (int i = 0; i <= NTMR; i++) begin
      if (tsel == TSW'(i)) sel_raw = srcs[i];
    end
  end

  assign sig  = sel_raw ^ inv;
  assign trig = sig & ~sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHW  = 4,
  parameter int RESW = 10,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            trig,
  input  logic            auto_go,
  input  logic [1:0]      mode,
  input  logic [1:0]      sht,
  input  logic [DIVW-1:0] div,
  input  logic [CHW-1:0]  chan_sel,
  input  logic [RESW-1:0] conv_code,
  output logic            busy,
  output logic            conv_hold,
  output logic [CHW-1:0]  conv_chan,
  output logic            res_load,
  output logic [RESW-1:0] res_raw
);

  localparam logic [TICK_W-1:0] CONV_LAST = TICK_W'(CONV_TICKS - 1);

  seq_state_t        st, st_n;
  logic [DIVW-1:0]   div_cnt, div_cnt_n;
  logic [TICK_W-1:0] tick_cnt, tick_cnt_n;
  logic [CHW-1:0]    chan_cur, chan_cur_n;
  logic [RESW-1:0]   res_n;
  logic              tick, last_chan;

  assign tick      = (div_cnt >= div);
  assign last_chan = (chan_cur == '0);
  assign busy      = (st != ST_IDLE);
  assign conv_hold = (st == ST_SAMPLE);
  assign conv_chan = chan_cur;

  always_comb begin
    st_n       = st;
    div_cnt_n  = div_cnt;
    tick_cnt_n = tick_cnt;
    chan_cur_n = chan_cur;
    res_n      = res_raw;
    res_load   = 1'b0;

    case (st)
      ST_IDLE: begin
        if (en && trig) begin
          st_n       = ST_SAMPLE;
          div_cnt_n  = '0;
          tick_cnt_n = '0;
          chan_cur_n = chan_sel;
        end
      end
      ST_WAIT: begin
        if (!en) begin
          st_n = ST_IDLE;
        end else if (trig) begin
          st_n       = ST_SAMPLE;
          div_cnt_n  = '0;
          tick_cnt_n = '0;
        end
      end
      ST_SAMPLE: begin
        div_cnt_n = tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (tick_cnt == sample_len(sht) - 1'b1) begin
            st_n       = ST_CONV;
            tick_cnt_n = '0;
          end else begin
            tick_cnt_n = tick_cnt + 1'b1;
          end
        end
      end
      default: begin
        div_cnt_n = tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (tick_cnt == CONV_LAST) begin
            res_load   = 1'b1;
            res_n      = conv_code;
            tick_cnt_n = '0;
            st_n       = auto_go ? ST_SAMPLE : ST_WAIT;
            case (mode)
              MODE_SINGLE: st_n = ST_IDLE;
              MODE_SEQ: begin
                if (last_chan) st_n = ST_IDLE;
                else           chan_cur_n = chan_cur - 1'b1;
              end
              MODE_REP1: begin
                if (!en) st_n = ST_IDLE;
              end
              default: begin
                chan_cur_n = last_chan ? chan_sel : chan_cur - 1'b1;
                if (!en) st_n = ST_IDLE;
              end
            endcase
          end else begin
            tick_cnt_n = tick_cnt + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      div_cnt  <= '0;
      tick_cnt <= '0;
      chan_cur <= '0;
      res_raw  <= '0;
    end else begin
      st       <= st_n;
      div_cnt  <= div_cnt_n;
      tick_cnt <= tick_cnt_n;
      chan_cur <= chan_cur_n;
      if (res_load) res_raw <= res_n;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int BUSW = 16,
  parameter int RESW = 10,
  parameter int CHW  = 4,
  parameter int DIVW = 3,
  parameter int NTMR = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [BUSW-1:0] wdata,
  input  logic [1:0]      rd_addr,
  output logic [BUSW-1:0] rdata,
  input  logic            irq_ack,
  input  logic [NTMR-1:0] tmr_trig,
  output logic            irq,
  output logic            busy,
  output logic            conv_hold,
  output logic [CHW-1:0]  conv_chan,
  input  logic [RESW-1:0] conv_code
);

  localparam int TSW    = $clog2(NTMR + 1);
  localparam int PADW   = BUSW - RESW;
  localparam int CH_LSB = BUSW - CHW;

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            go, en, flag, ie, auto_go, inv, fmt, trig, res_load;
  logic [1:0]      sht, mode;
  logic [DIVW-1:0] div;
  logic [TSW-1:0]  tsel;
  logic [CHW-1:0]  chan_sel;
  logic [RESW-1:0] res_raw;
  logic [BUSW-1:0] res_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  adc_seq_regs #(.BUSW(BUSW), .CHW(CHW), .DIVW(DIVW), .TSW(TSW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wdata    (wdata),
    .res_load (res_load),
    .irq_ack  (irq_ack),
    .go       (go),
    .en       (en),
    .flag     (flag),
    .ie       (ie),
    .auto_go  (auto_go),
    .sht      (sht),
    .mode     (mode),
    .div      (div),
    .tsel     (tsel),
    .inv      (inv),
    .fmt      (fmt),
    .chan     (chan_sel)
  );

  adc_seq_trig #(.NTMR(NTMR), .TSW(TSW)) u_trig (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .go    (go),
    .tmr   (tmr_trig),
    .tsel  (tsel),
    .inv   (inv),
    .trig  (trig)
  );

  adc_seq_fsm #(.CHW(CHW), .RESW(RESW), .DIVW(DIVW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .trig      (trig),
    .auto_go   (auto_go),
    .mode      (mode),
    .sht       (sht),
    .div       (div),
    .chan_sel  (chan_sel),
    .conv_code (conv_code),
    .busy      (busy),
    .conv_hold (conv_hold),
    .conv_chan (conv_chan),
    .res_load  (res_load),
    .res_raw   (res_raw)
  );

  assign irq = flag & ie;

  generate
    if (PADW > 0) begin : g_pad
      assign res_word = fmt ? {~res_raw[RESW-1], res_raw[RESW-2:0], {PADW{1'b0}}}
                            : {{PADW{1'b0}}, res_raw};
    end else begin : g_nopad
      assign res_word = fmt ? {~res_raw[RESW-1], res_raw[RESW-2:0]} : res_raw;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (rd_addr)
      ADDR_CTL_A: begin
        rdata[A_GO]       = go;
        rdata[A_EN]       = en;
        rdata[A_FLAG]     = flag;
        rdata[A_IE]       = ie;
        rdata[A_AUTO]     = auto_go;
        rdata[A_SHT +: 2] = sht;
        rdata[BUSW-1]     = busy;
      end
      ADDR_CTL_B: begin
        rdata[B_MODE +: 2]   = mode;
        rdata[B_DIV +: DIVW] = div;
        rdata[B_TSEL +: TSW] = tsel;
        rdata[B_INV]         = inv;
        rdata[B_FMT]         = fmt;
        rdata[CH_LSB +: CHW] = chan_sel;
      end
      ADDR_RES: rdata = res_word;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CHW  = 4,
  parameter int TSW  = 2,
  parameter int BUSW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            busy,
  input logic            conv_hold,
  input logic            res_load,
  input logic            flag,
  input logic            irq_ack,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [BUSW-1:0] wdata,
  input logic [1:0]      mode,
  input logic [1:0]      sht,
  input logic            auto_go,
  input logic [TSW-1:0]  tsel,
  input logic [CHW-1:0]  chan_sel,
  input logic [CHW-1:0]  conv_chan
);

  logic [CHW+TSW+4:0] locked;
  logic               flag_wr_one;

  assign locked      = {sht, auto_go, mode, tsel, chan_sel};
  assign flag_wr_one = wr_en && (wr_addr == 2'd0) && wdata[2];

  // R2: the sample window lies inside the busy period
  a_r2_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_hold |-> busy);

  // R3: a single conversion leaves the block idle
  a_r3_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && mode == 2'd0) |=> !busy);

  // R4: a sequence steps one channel down after each result
  a_r4_seq_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && mode == 2'd1 && conv_chan != '0) |=> (conv_chan == $past(conv_chan) - 1'b1));

  // R6: activity only starts while enabled
  a_r6_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  // R9: locked fields hold while enabled
  a_r9_lock: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(locked));

  // R10: a loaded result raises the flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> flag);

  // R10: acknowledge clears the flag
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !res_load && !flag_wr_one) |=> !flag);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHW(CHW), .TSW(TSW), .BUSW(BUSW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (en),
  .busy      (busy),
  .conv_hold (conv_hold),
  .res_load  (res_load),
  .flag      (flag),
  .irq_ack   (irq_ack),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wdata     (wdata),
  .mode      (mode),
  .sht       (sht),
  .auto_go   (auto_go),
  .tsel      (tsel),
  .chan_sel  (chan_sel),
  .conv_chan (conv_chan)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en, irq_ack, irq, busy, conv_hold;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wdata, rdata;
  logic [2:0]  tmr_trig;
  logic [3:0]  conv_chan;
  logic [9:0]  conv_code;
  logic [5:0]  seed;

  int          checks, errors, n_pop;
  bit          mon_en, finished;
  logic [15:0] exp_q[$];

  assign conv_code = {conv_chan, seed};

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .irq_ack(irq_ack), .tmr_trig(tmr_trig),
    .irq(irq), .busy(busy), .conv_hold(conv_hold), .conv_chan(conv_chan),
    .conv_code(conv_code)
  );

  function automatic logic [15:0] mk_a(bit go, bit en, bit flg, bit ie, bit au, logic [1:0] sht);
    return {9'd0, sht, au, ie, flg, en, go};
  endfunction

  function automatic logic [15:0] mk_b(logic [1:0] md, logic [2:0] dv, logic [1:0] ts,
                                       bit iv, bit fm, logic [3:0] ch);
    return {ch, 3'd0, fm, iv, ts, dv, md};
  endfunction

  function automatic logic [15:0] fmt_res(logic [3:0] ch, bit fm);
    logic [9:0] raw;
    raw = {ch, seed};
    return fm ? {~raw[9], raw[8:0], 6'd0} : {6'd0, raw};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(posedge clk);
    #2 rd_addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pop(int n, string tag);
    int g = 0;
    while (n_pop < n && g < 20000) begin
      @(negedge clk);
      g++;
    end
    check(tag, n_pop, n);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    tmr_trig[idx] = ~tmr_trig[idx];
    repeat (2) @(negedge clk);
    tmr_trig[idx] = ~tmr_trig[idx];
  endtask

  task automatic setup(logic [1:0] md, logic [2:0] dv, logic [1:0] ts, bit iv, bit fm,
                       logic [3:0] ch, bit au, logic [1:0] sht, bit ie);
    wr(2'd0, mk_a(0, 0, 0, ie, au, sht));
    tmr_trig = {3{iv}};
    wr(2'd1, mk_b(md, dv, ts, iv, fm, ch));
  endtask

  // scoreboard monitor: pops one expected item per interrupt
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && irq) begin
        rd_addr = 2'd2;
        #1;
        if (exp_q.size() == 0) begin
          check("R3 R4 R5 R6 unexpected result", rdata, 16'hxxxx);
        end else begin
          check("R3 R4 R5 R11 result", rdata, exp_q.pop_front());
        end
        n_pop++;
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R10 ack clears irq", irq, 1'b0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int bcnt, hcnt, n0;
    int sh_len[4];
    sh_len = '{4, 8, 16, 64};
    checks = 0; errors = 0; n_pop = 0; finished = 0; mon_en = 1;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wdata = '0; rd_addr = '0;
    irq_ack = 1'b0; tmr_trig = '0; seed = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    rd(2'd0, d); check("R1 ctl A", d, 16'h0000);
    rd(2'd1, d); check("R1 ctl B", d, 16'h0000);
    rd(2'd2, d); check("R1 result", d, 16'h0000);
    check("R1 busy", busy, 1'b0);
    check("R1 irq", irq, 1'b0);

    // R2 timing and R3 single conversion
    for (int i = 0; i < 4; i++) begin
      logic [1:0] sh;
      logic [2:0] dv;
      sh = 2'(i);
      dv = (i == 0) ? 3'd0 : (i == 1) ? 3'd2 : (i == 2) ? 3'd1 : 3'd7;
      seed = 6'(i + 1);
      setup(2'd0, dv, 2'd0, 0, 0, 4'(i + 3), 0, sh, 1);
      exp_q.push_back(fmt_res(4'(i + 3), 0));
      n0 = n_pop;
      wr(2'd0, mk_a(1, 1, 0, 1, 0, sh));
      bcnt = 0; hcnt = 0;
      do begin
        @(negedge clk);
        if (busy) bcnt++;
        if (conv_hold) hcnt++;
      end while ((busy || bcnt == 0) && bcnt < 2000);
      check("R2 busy length", bcnt, (sh_len[i] + 13) * (int'(dv) + 1));
      check("R2 sample length", hcnt, sh_len[i] * (int'(dv) + 1));
      wait_pop(n0 + 1, "R3 single result");
      idle(30);
      check("R3 one result only", n_pop, n0 + 1);
    end

    // R8 start bit self clears, enable set in same write
    rd(2'd0, d);
    check("R8 start bit reads 0", d[0], 1'b0);
    check("R8 enable kept", d[1], 1'b1);

    // R11 left-justified format
    seed = 6'h2A;
    setup(2'd0, 3'd0, 2'd0, 0, 1, 4'd5, 0, 2'd0, 1);
    exp_q.push_back(fmt_res(4'd5, 1));
    n0 = n_pop;
    wr(2'd0, mk_a(1, 1, 0, 1, 0, 2'd0));
    wait_pop(n0 + 1, "R11 left-justified low");
    setup(2'd0, 3'd0, 2'd0, 0, 1, 4'd9, 0, 2'd0, 1);
    exp_q.push_back(fmt_res(4'd9, 1));
    wr(2'd0, mk_a(1, 1, 0, 1, 0, 2'd0));
    wait_pop(n0 + 2, "R11 left-justified high");

    // R4 sequence with auto restart (R6)
    seed = 6'h11;
    setup(2'd1, 3'd0, 2'd0, 0, 0, 4'd3, 1, 2'd0, 1);
    for (int c = 3; c >= 0; c--) exp_q.push_back(fmt_res(4'(c), 0));
    n0 = n_pop;
    wr(2'd0, mk_a(1, 1, 0, 1, 1, 2'd0));
    wait_pop(n0 + 4, "R4 R6 auto sequence");
    wait_idle();
    idle(40);
    check("R4 sequence ends idle", busy, 1'b0);
    check("R4 no extra result", n_pop, n0 + 4);

    // R6 R7 sequence stepped by timer 0, start bit not selected
    seed = 6'h05;
    setup(2'd1, 3'd0, 2'd1, 0, 0, 4'd2, 0, 2'd0, 1);
    for (int c = 2; c >= 0; c--) exp_q.push_back(fmt_res(4'(c), 0));
    n0 = n_pop;
    wr(2'd0, mk_a(1, 1, 0, 1, 0, 2'd0));
    idle(40);
    check("R7 start bit ignored when timer selected", busy, 1'b0);
    check("R7 no result from start bit", n_pop, n0);
    pulse(0);
    wait_pop(n0 + 1, "R7 timer 0 trigger");
    idle(60);
    check("R6 waits for next edge", n_pop, n0 + 1);
    check("R6 sequence still busy", busy, 1'b1);
    pulse(0);
    wait_pop(n0 + 2, "R6 second edge");
    pulse(0);
    wait_pop(n0 + 3, "R6 third edge");
    idle(5);
    check("R4 stepped sequence ends idle", busy, 1'b0);

    // R5 R7 repeat single channel, inverted timer 2
    seed = 6'h3C;
    setup(2'd2, 3'd0, 2'd3, 1, 0, 4'd6, 0, 2'd0, 1);
    for (int k = 0; k < 3; k++) exp_q.push_back(fmt_res(4'd6, 0));
    n0 = n_pop;
    wr(2'd0, mk_a(0, 1, 0, 1, 0, 2'd0));
    for (int k = 0; k < 3; k++) begin
      pulse(2);
      wait_pop(n0 + k + 1, "R7 inverted timer 2 trigger");
    end
    pulse(0);
    idle(40);
    check("R7 unselected timer ignored", n_pop, n0 + 3);
    check("R5 repeat stays active", busy, 1'b1);
    wr(2'd0, mk_a(0, 0, 0, 1, 0, 2'd0));
    idle(3);
    check("R5 enable clear stops repeat", busy, 1'b0);
    pulse(2);
    idle(40);
    check("R5 no start while disabled", n_pop, n0 + 3);

    // R5 repeat sequence with auto, stop finishes current conversion
    seed = 6'h07;
    setup(2'd3, 3'd1, 2'd0, 0, 0, 4'd1, 1, 2'd0, 1);
    exp_q.push_back(fmt_res(4'd1, 0));
    exp_q.push_back(fmt_res(4'd0, 0));
    exp_q.push_back(fmt_res(4'd1, 0));
    exp_q.push_back(fmt_res(4'd0, 0));
    n0 = n_pop;
    wr(2'd0, mk_a(1, 1, 0, 1, 1, 2'd0));
    wait_pop(n0 + 3, "R5 repeat sequence");
    wr(2'd0, mk_a(0, 0, 0, 1, 1, 2'd0));
    wait_idle();
    idle(50);
    check("R5 current conversion completed", n_pop, n0 + 4);
    check("R5 queue drained", exp_q.size(), 0);

    // R6 trigger during conversion ignored
    seed = 6'h19;
    setup(2'd0, 3'd0, 2'd2, 0, 0, 4'd8, 0, 2'd1, 1);
    exp_q.push_back(fmt_res(4'd8, 0));
    n0 = n_pop;
    wr(2'd0, mk_a(0, 1, 0, 1, 0, 2'd1));
    pulse(1);
    idle(6);
    pulse(1);
    wait_pop(n0 + 1, "R6 busy trigger result");
    idle(60);
    check("R6 busy trigger ignored", n_pop, n0 + 1);

    // R9 lock while enabled
    wr(2'd1, mk_b(2'd3, 3'd4, 2'd1, 0, 1, 4'd11));
    rd(2'd1, d);
    check("R9 locked B fields", d, mk_b(2'd0, 3'd4, 2'd2, 0, 1, 4'd8));
    wr(2'd0, mk_a(0, 1, 0, 1, 1, 2'd3));
    rd(2'd0, d);
    check("R9 locked A fields", d, mk_a(0, 1, 0, 1, 0, 2'd1));
    exp_q.push_back(fmt_res(4'd8, 1));
    pulse(1);
    wait_pop(n0 + 2, "R9 old channel used");

    // R10 flag and interrupt enable
    mon_en = 0;
    seed = 6'h01;
    setup(2'd0, 3'd0, 2'd0, 0, 0, 4'd4, 0, 2'd0, 0);
    wr(2'd0, mk_a(1, 1, 0, 0, 0, 2'd0));
    idle(2);
    wait_idle();
    idle(2);
    rd(2'd0, d);
    check("R10 flag set on load", d[2], 1'b1);
    check("R10 irq masked", irq, 1'b0);
    wr(2'd0, mk_a(0, 1, 1, 1, 0, 2'd0));
    idle(1);
    check("R10 irq when enabled", irq, 1'b1);
    wr(2'd0, mk_a(0, 1, 0, 1, 0, 2'd0));
    idle(1);
    check("R10 write 0 clears irq", irq, 1'b0);
    rd(2'd0, d);
    check("R10 write 0 clears flag", d[2], 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule